// File: doc/BRIEF.md
# Staged Frequency Register Latch

This block is the front end of an FM synthesizer's register file. It holds the pitch setting of every channel and passes it to the phase generator. A CPU-side port supplies one byte per cycle, together with an address and a bank select. Each pitch setting spans two bytes. The upper byte carries a 3-bit octave block and the top three bits of an 11-bit frequency number. The lower byte carries the remaining eight frequency bits.

Writing the upper byte never changes what the phase generator sees. The upper byte is parked in a per-channel staging register. The live setting of a channel is replaced only when that same channel's lower byte is written. At that point the staged upper byte and the new lower byte land together in one clock edge. The third channel of the first bank also has three extra per-operator pitch settings, and these obey the same two-step rule. Software must therefore write the upper byte first. A program that writes the bytes in the other order keeps hearing the old upper byte until the next lower-byte write.

Top module: `fm_freq_latch`

## Requirements
- R1: After reset, every staged byte and every live block and frequency number is zero.
- R2: A write to an upper-byte address (low nibble 0x4 to 0x6 for channels, 0xC to 0xE for operator slots, high nibble 0xA) leaves all outputs unchanged.
- R3: A write of data D to a lower-byte address 0xA0 to 0xA2 sets that channel's live block to staged bits 5:3, and its live frequency number to {staged bits 2:0, D}, one cycle after the write.
- R4: A staged upper byte survives any number of writes to other channels or slots, is not committed by another channel's lower-byte write, and remains staged after it has been committed.
- R5: The write sequence upper 0x1E, lower 0xFF, upper 0x24 to one channel leaves that channel at block 3 and frequency number 0x6FF.
- R6: With bank select 0, address offsets 0 to 2 reach channels 0 to 2. With bank select 1, they reach channels 3 to 5.
- R7: The operator slots 0 to 2 use lower bytes at 0xA8 to 0xAA and upper bytes at 0xAC to 0xAE, under the same staging rule. They respond only when bank select is 0. The same addresses with bank select 1 change nothing.
- R8: A write has no effect when the enable is low, and none at undecoded addresses such as 0xA3, 0xA7, 0xAB, 0xAF or any address outside 0xA0 to 0xAF.
- R9: In any one cycle, at most one channel or slot changes its live setting, and the block and frequency number of that channel or slot change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one byte |
| bankSel | input | 1 | Selects the channel bank (0 or 1) |
| wrAddr | input | 8 | Register address |
| wrData | input | 8 | Byte written |
| chanBlock | output | 18 | Live 3-bit block per channel, channel 0 in the low bits |
| chanFnum | output | 66 | Live 11-bit frequency number per channel |
| opBlock | output | 9 | Live 3-bit block per operator slot |
| opFnum | output | 33 | Live 11-bit frequency number per operator slot |

## Verification
The bench builds the block with its defaults: two banks of three channels, plus three operator slots. With only nine slots, every channel and slot can be swept with sixteen different upper and lower byte pairs. After every write, all nine live settings are compared against an arithmetic model of the staging rule. At this size, every decoded address, both bank selects, and each undecoded hole in the 0xA0 to 0xAF window can be exercised.

// File: rtl/fm_freq_pkg.sv
package fm_freq_pkg;
  localparam int BLK_W   = 3;
  localparam int FNUM_W  = 11;
  localparam int STAGE_W = 6;
  localparam int LIVE_W  = BLK_W + FNUM_W;
  localparam int SLOT_W  = 4;
  localparam int OP_SLOTS = 3;

  typedef struct packed {
    logic              hiWr;
    logic              loWr;
    logic [SLOT_W-1:0] slot;
    logic [7:0]        data;
  } freqStrobe_t;
endpackage

// File: rtl/fm_freq_ctrl.sv
module fm_freq_ctrl
  import fm_freq_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int CHAN_PER_BANK = 3,
  parameter int BANK_W        = 1
) (
  input  logic              wrEn,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [7:0]        wrAddr,
  input  logic [7:0]        wrData,
  output freqStrobe_t       strb
);
  localparam int NUM_CH = NUM_BANKS * CHAN_PER_BANK;
  localparam logic [1:0] CH_SUB_MAX = 2'(CHAN_PER_BANK - 1);
  localparam logic [1:0] OP_SUB_MAX = 2'(OP_SLOTS - 1);
  localparam logic [SLOT_W-1:0] CH_LIM = SLOT_W'(NUM_CH);

  logic [1:0]        sub;
  logic [SLOT_W-1:0] chanIdx;
  logic [SLOT_W-1:0] opIdx;
  logic              inWindow;

  assign sub      = wrAddr[1:0];
  assign inWindow = wrEn && (wrAddr[7:4] == 4'hA);
  assign chanIdx  = SLOT_W'(bankSel) * SLOT_W'(CHAN_PER_BANK) + SLOT_W'(sub);
  assign opIdx    = CH_LIM + SLOT_W'(sub);

  always_comb begin
    strb      = '0;
    strb.data = wrData;
    if (inWindow) begin
      unique case (wrAddr[3:2])
        2'd0: if (sub <= CH_SUB_MAX && chanIdx < CH_LIM) begin
          strb.loWr = 1'b1;
          strb.slot = chanIdx;
        end
        2'd1: if (sub <= CH_SUB_MAX && chanIdx < CH_LIM) begin
          strb.hiWr = 1'b1;
          strb.slot = chanIdx;
        end
        2'd2: if (sub <= OP_SUB_MAX && bankSel == '0) begin
          strb.loWr = 1'b1;
          strb.slot = opIdx;
        end
        default: if (sub <= OP_SUB_MAX && bankSel == '0) begin
          strb.hiWr = 1'b1;
          strb.slot = opIdx;
        end
      endcase
    end
  end
endmodule

// File: rtl/fm_freq_dp.sv
module fm_freq_dp
  import fm_freq_pkg::*;
#(
  parameter int NUM_SLOTS = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  freqStrobe_t                 strb,
  output logic [NUM_SLOTS*BLK_W-1:0]  slotBlock,
  output logic [NUM_SLOTS*FNUM_W-1:0] slotFnum
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [STAGE_W-1:0] stageReg;
    logic [LIVE_W-1:0]  liveReg;
    logic               hit;

    assign hit = (strb.slot == SLOT_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageReg <= '0;
        liveReg  <= '0;
      end else begin
        if (strb.hiWr && hit) stageReg <= strb.data[STAGE_W-1:0];
        if (strb.loWr && hit) liveReg  <= {stageReg, strb.data};
      end
    end

    assign slotBlock[s*BLK_W +: BLK_W]   = liveReg[LIVE_W-1 -: BLK_W];
    assign slotFnum[s*FNUM_W +: FNUM_W]  = liveReg[FNUM_W-1:0];
  end
endmodule

// File: rtl/fm_freq_latch.sv
module fm_freq_latch
  import fm_freq_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int CHAN_PER_BANK = 3,
  localparam int NUM_CH       = NUM_BANKS * CHAN_PER_BANK,
  localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [BANK_W-1:0]            bankSel,
  input  logic [7:0]                   wrAddr,
  input  logic [7:0]                   wrData,
  output logic [NUM_CH*BLK_W-1:0]      chanBlock,
  output logic [NUM_CH*FNUM_W-1:0]     chanFnum,
  output logic [OP_SLOTS*BLK_W-1:0]    opBlock,
  output logic [OP_SLOTS*FNUM_W-1:0]   opFnum
);
  localparam int NUM_SLOTS = NUM_CH + OP_SLOTS;

  freqStrobe_t                  strb;
  logic [NUM_SLOTS*BLK_W-1:0]   slotBlock;
  logic [NUM_SLOTS*FNUM_W-1:0]  slotFnum;

  fm_freq_ctrl #(
    .NUM_BANKS(NUM_BANKS), .CHAN_PER_BANK(CHAN_PER_BANK), .BANK_W(BANK_W)
  ) i_ctrl (
    .wrEn(wrEn), .bankSel(bankSel), .wrAddr(wrAddr), .wrData(wrData), .strb(strb)
  );

  fm_freq_dp #(.NUM_SLOTS(NUM_SLOTS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .slotBlock(slotBlock), .slotFnum(slotFnum)
  );

  assign chanBlock = slotBlock[NUM_CH*BLK_W-1:0];
  assign chanFnum  = slotFnum[NUM_CH*FNUM_W-1:0];
  assign opBlock   = slotBlock[NUM_SLOTS*BLK_W-1:NUM_CH*BLK_W];
  assign opFnum    = slotFnum[NUM_SLOTS*FNUM_W-1:NUM_CH*FNUM_W];
endmodule

// File: rtl/fm_freq_checker.sv
module fm_freq_checker
  import fm_freq_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CHAN_PER_BANK = 3,
  parameter int BANK_W = 1
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic [BANK_W-1:0]          bankSel,
  input logic [7:0]                 wrAddr,
  input logic [7:0]                 wrData,
  input logic [NUM_CH*BLK_W-1:0]    chanBlock,
  input logic [NUM_CH*FNUM_W-1:0]   chanFnum,
  input logic [OP_SLOTS*BLK_W-1:0]  opBlock,
  input logic [OP_SLOTS*FNUM_W-1:0] opFnum
);
  localparam int NUM_SLOTS = NUM_CH + OP_SLOTS;
  localparam int ALL_W = NUM_SLOTS * LIVE_W;

  logic [ALL_W-1:0] allOut;
  logic [ALL_W-1:0] prevOut;
  logic             prevValid;
  logic [NUM_SLOTS-1:0] chg;
  logic             isHi, isOpBank1, isLoChan;
  logic             loPend;
  logic [SLOT_W-1:0] loIdx;
  logic [7:0]       loData;
  logic [7:0]       pickedLow;

  assign allOut    = {opFnum, opBlock, chanFnum, chanBlock};
  assign isHi      = wrEn && wrAddr[7:4] == 4'hA && wrAddr[2];
  assign isOpBank1 = wrEn && bankSel != '0 && wrAddr[7:3] == 5'b10101;
  assign isLoChan  = wrEn && wrAddr[7:2] == 6'b101000 && wrAddr[1:0] != 2'd3;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chg
    if (s < NUM_CH) begin : g_ch
      assign chg[s] = {chanBlock[s*BLK_W +: BLK_W], chanFnum[s*FNUM_W +: FNUM_W]} !=
                      {prevOut[s*BLK_W +: BLK_W], prevOut[NUM_CH*BLK_W + s*FNUM_W +: FNUM_W]};
    end else begin : g_op
      localparam int O = s - NUM_CH;
      localparam int OB = NUM_CH*LIVE_W;
      assign chg[s] = {opBlock[O*BLK_W +: BLK_W], opFnum[O*FNUM_W +: FNUM_W]} !=
                      {prevOut[OB + O*BLK_W +: BLK_W], prevOut[OB + OP_SLOTS*BLK_W + O*FNUM_W +: FNUM_W]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOut <= '0; prevValid <= 1'b0;
      loPend <= 1'b0; loIdx <= '0; loData <= '0;
    end else begin
      prevOut   <= allOut;
      prevValid <= 1'b1;
      loPend    <= isLoChan;
      loIdx     <= SLOT_W'(bankSel) * SLOT_W'(CHAN_PER_BANK) + SLOT_W'(wrAddr[1:0]);
      loData    <= wrData;
    end
  end

  always_comb begin
    pickedLow = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (loIdx == SLOT_W'(c)) pickedLow = chanFnum[c*FNUM_W +: 8];
  end

  assert_hi_staged_R2: assert property (@(posedge clk) disable iff (!rstN)
    isHi |=> $stable(allOut));

  assert_lo_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    loPend |-> pickedLow == loData);

  assert_op_bank1_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    isOpBank1 |=> $stable(allOut));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(allOut));

  assert_one_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
    prevValid |-> $countones(chg) <= 1);
endmodule

bind fm_freq_latch fm_freq_checker #(
  .NUM_CH(NUM_CH), .CHAN_PER_BANK(CHAN_PER_BANK), .BANK_W(BANK_W)
) i_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .bankSel(bankSel), .wrAddr(wrAddr),
  .wrData(wrData), .chanBlock(chanBlock), .chanFnum(chanFnum),
  .opBlock(opBlock), .opFnum(opFnum)
);

// File: tb/test_fm_freq_latch.sv
module test_fm_freq_latch;
  localparam int NCH = 6;
  localparam int NSL = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic bankSel = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [17:0] chanBlock;
  logic [65:0] chanFnum;
  logic [8:0]  opBlock;
  logic [32:0] opFnum;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0]  mStage [NSL];
  logic [13:0] mLive  [NSL];

  always #10 clk = ~clk;

  fm_freq_latch i_fm_freq_latch (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .bankSel(bankSel), .wrAddr(wrAddr),
    .wrData(wrData), .chanBlock(chanBlock), .chanFnum(chanFnum),
    .opBlock(opBlock), .opFnum(opFnum)
  );

  function automatic logic [13:0] actual(int s);
    if (s < NCH) return {chanBlock[s*3 +: 3], chanFnum[s*11 +: 11]};
    return {opBlock[(s-NCH)*3 +: 3], opFnum[(s-NCH)*11 +: 11]};
  endfunction

  task automatic compareAll(string req);
    for (int s = 0; s < NSL; s++) begin
      checks++;
      if (actual(s) !== mLive[s]) begin
        errors++;
        $display("FAIL %s slot %0d actual %h expected %h", req, s, actual(s), mLive[s]);
      end
    end
  endtask

  // model of the addressing and staging rules (R2, R3, R6, R7, R8)
  task automatic wr(input logic en, input logic bank, input logic [7:0] addr,
                    input logic [7:0] data, input string req);
    int sub;
    int slot;
    bit isLo;
    @(negedge clk);
    wrEn = en; bankSel = bank; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    sub = int'(addr[1:0]);
    slot = -1;
    isLo = 1'b0;
    if (en && addr[7:4] == 4'hA && sub < 3) begin
      case (addr[3:2])
        2'd0: begin slot = int'(bank)*3 + sub; isLo = 1'b1; end
        2'd1: slot = int'(bank)*3 + sub;
        2'd2: if (!bank) begin slot = NCH + sub; isLo = 1'b1; end
        default: if (!bank) slot = NCH + sub;
      endcase
    end
    if (slot >= 0) begin
      if (isLo) mLive[slot] = {mStage[slot], data};
      else mStage[slot] = data[5:0];
    end
    compareAll(req);
  endtask

  task automatic checkOne(int s, logic [13:0] exp, string req);
    checks++;
    if (actual(s) !== exp) begin
      errors++;
      $display("FAIL %s slot %0d actual %h expected %h", req, s, actual(s), exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSL; s++) begin mStage[s] = '0; mLive[s] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R2: staging only, outputs stay at reset value
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 3; c++)
        wr(1'b1, b[0], 8'hA4 + 8'(c), 8'(8'h11 * (b*3 + c + 1)), "R2");
    for (int o = 0; o < 3; o++) wr(1'b1, 1'b0, 8'hAC + 8'(o), 8'(8'h2A + o), "R2 R7");

    // R3 R6 R7: sweep every slot with sixteen byte pairs
    for (int k = 0; k < 16; k++) begin
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 3; c++) begin
          wr(1'b1, b[0], 8'hA4 + 8'(c), 8'((k*13 + (b*3+c)*7) & 8'hFF), "R2 R6");
          wr(1'b1, b[0], 8'hA0 + 8'(c), 8'((k*37 + b*3 + c) & 8'hFF), "R3 R6");
        end
      for (int o = 0; o < 3; o++) begin
        wr(1'b1, 1'b0, 8'hAC + 8'(o), 8'((k*11 + o*5) & 8'hFF), "R7");
        wr(1'b1, 1'b0, 8'hA8 + 8'(o), 8'((k*53 + o) & 8'hFF), "R7");
      end
    end

    // R4: pending value on channel 1 survives other traffic
    wr(1'b1, 1'b0, 8'hA5, 8'h2D, "R4");
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 3; c++)
        if (!(b == 0 && c == 1)) begin
          wr(1'b1, b[0], 8'hA4 + 8'(c), 8'h3F, "R4");
          wr(1'b1, b[0], 8'hA0 + 8'(c), 8'h5A, "R4");
        end
    wr(1'b1, 1'b0, 8'hA9, 8'h77, "R4");
    wr(1'b1, 1'b0, 8'hA1, 8'hC3, "R4");
    checkOne(1, {3'd5, 3'd5, 8'hC3}, "R4");
    wr(1'b1, 1'b0, 8'hA1, 8'h04, "R4");
    checkOne(1, {3'd5, 3'd5, 8'h04}, "R4 restaged reuse");

    // R5: out-of-order sequence on channel 2
    wr(1'b1, 1'b0, 8'hA6, 8'h1E, "R5");
    wr(1'b1, 1'b0, 8'hA2, 8'hFF, "R5");
    wr(1'b1, 1'b0, 8'hA6, 8'h24, "R5");
    checkOne(2, {3'd3, 11'h6FF}, "R5");

    // R7: operator addresses with bank 1 change nothing
    for (int o = 0; o < 3; o++) begin
      wr(1'b1, 1'b1, 8'hAC + 8'(o), 8'h01, "R7 bank1");
      wr(1'b1, 1'b1, 8'hA8 + 8'(o), 8'h99, "R7 bank1");
    end

    // R8: undecoded addresses and disabled writes
    wr(1'b1, 1'b0, 8'hA3, 8'hEE, "R8");
    wr(1'b1, 1'b0, 8'hA7, 8'hEE, "R8");
    wr(1'b1, 1'b0, 8'hAB, 8'hEE, "R8");
    wr(1'b1, 1'b0, 8'hAF, 8'hEE, "R8");
    wr(1'b1, 1'b0, 8'hB0, 8'hEE, "R8");
    wr(1'b1, 1'b1, 8'h20, 8'hEE, "R8");
    wr(1'b0, 1'b0, 8'hA0, 8'hEE, "R8 disabled");
    wr(1'b0, 1'b1, 8'hA8, 8'hEE, "R8 disabled");

    // R9: a commit moves block and frequency together on one slot
    wr(1'b1, 1'b1, 8'hA6, 8'h3B, "R9");
    wr(1'b1, 1'b1, 8'hA2, 8'h81, "R9");
    checkOne(5, {3'd7, 3'd3, 8'h81}, "R9");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule